// File: doc/BRIEF.md
# I2C Multimaster Bus-Busy Monitor

This block sits beside a multimaster I2C controller and decides whether the shared bus is in use. It watches the raw SDA and SCL lines through a synchronizer. A START edge, or the low-SDA/high-SCL level that an acknowledge leaves on the wire, marks the bus busy. A STOP edge marks it free and emits a single-cycle bus-free pulse.

After a reset the busy flag is only a guess taken from the line levels. Another master may be in the middle of a transfer, so the flag is flagged untrustworthy. It is trusted once the monitor has seen real bus activity, or once both lines have stayed high for a whole idle window. If neither happens within an overall timeout, a timeout flag is raised and qualification stops. While the flag is untrusted, start requests from the controller are held back and reported as blocked.

The idle window and the timeout are counted in clock cycles. Their defaults correspond to 10 ms and 100 ms at a 100 MHz clock.

Top module: `i2c_busy_monitor`

## Requirements
- R1: While `rst` is high, `busy` is loaded with 1 when the raw lines read SDA=0 and SCL=1, and with 0 for every other SDA/SCL combination. `bus_free`, `busy_valid` and `qual_timeout` are 0 during reset.
- R2: While tracking, a falling SDA edge with SCL high (START) sets `busy`.
- R3: While tracking, SDA low with SCL high (acknowledge level) sets `busy`, even without a preceding SDA edge.
- R4: While tracking, a rising SDA edge with SCL high (STOP) clears `busy` and raises `bus_free` for exactly one cycle, in the same cycle that `busy` falls.
- R5: Tracking begins one clock after `ctl_en` is seen high. While tracking is off, `busy` holds its value.
- R6: Each line passes through a two-stage synchronizer. A line change driven before clock edge k is reflected on `busy` after edge k+2.
- R7: `busy_valid` is 0 after reset. It rises together with the first busy or bus-free event seen while tracking, and then stays 1 until the next reset.
- R8: With no event, `busy_valid` rises after SDA and SCL have both been sampled high for IDLE_CYC consecutive tracking cycles.
- R9: Any tracking sample with either line low restarts the idle count from zero.
- R10: If `busy_valid` has not risen within TMO_CYC tracking cycles, `qual_timeout` is set. After that, qualification stops, `busy_valid` stays 0 and `qual_timeout` stays 1 until reset.
- R11: `start_go` equals `start_req` when `busy_valid` is 1 and is 0 otherwise. `start_blocked` is `start_req` while `busy_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| ctl_en | input | 1 | Controller enable; tracking starts one clock after it is seen |
| start_req | input | 1 | Controller request to begin a transfer |
| busy | output | 1 | Bus-busy flag |
| bus_free | output | 1 | One-cycle pulse on a STOP |
| busy_valid | output | 1 | Busy flag can be trusted |
| qual_timeout | output | 1 | Qualification gave up |
| start_go | output | 1 | Start request passed through |
| start_blocked | output | 1 | Start request held back while busy is untrusted |

## Verification
Several properties are checked on every cycle:
- a START forcing busy on the next cycle;
- the bus-free pulse never coinciding with busy;
- busy holding still while tracking is off;
- the validity and timeout flags being sticky and mutually exclusive;
- the idle counter clearing after a low sample;
- start masking.

Some behaviours show only in the bench's scenarios:
- the line-dependent reset value;
- the exact synchronizer latency;
- the idle window landing on the right cycle;
- the window restarting after a one-cycle SCL glitch;
- the timeout freezing qualification while busy tracking carries on.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;
    typedef struct packed {
        logic sda;
        logic scl;
    } line_t;
endpackage

// File: rtl/i2cbm_sync.sv
module i2cbm_sync
    import i2cbm_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  line_t raw_i,
    output line_t sync_o,
    output logic  prev_sda_o
);
    typedef struct packed {
        line_t [STAGES-1:0] chain;
        logic               prev_sda;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev_sda = st_q.chain[STAGES-1].sda;
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                st_d.chain[i] = raw_i;
            end
            st_d.prev_sda = raw_i.sda;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_o     = st_q.chain[STAGES-1];
    assign prev_sda_o = st_q.prev_sda;
endmodule

// File: rtl/i2cbm_track.sv
module i2cbm_track
    import i2cbm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_req_i,
    input  line_t raw_i,
    input  line_t cur_i,
    input  logic  prev_sda_i,
    output logic  busy_o,
    output logic  free_o,
    output logic  trk_o,
    output logic  evt_o,
    output logic  hi_o
);
    typedef struct packed {
        logic en;
        logic busy;
        logic free;
    } trk_t;

    trk_t st_d, st_q;
    logic lvl, stop;

    always_comb begin
        lvl  = !cur_i.sda && cur_i.scl;
        stop = !prev_sda_i && cur_i.sda && cur_i.scl;
        st_d      = st_q;
        st_d.en   = en_req_i;
        st_d.free = st_q.en && stop;
        if (st_q.en) begin
            if (stop)     st_d.busy = 1'b0;
            else if (lvl) st_d.busy = 1'b1;
        end
        if (rst) begin
            st_d.en   = 1'b0;
            st_d.free = 1'b0;
            st_d.busy = !raw_i.sda && raw_i.scl;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign free_o = st_q.free;
    assign trk_o  = st_q.en;
    assign evt_o  = st_q.en && (lvl || stop);
    assign hi_o   = cur_i.sda && cur_i.scl;

    // R2: START seen while tracking makes the bus busy next cycle
    p_start_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (trk_o && prev_sda_i && !cur_i.sda && cur_i.scl) |=> busy_o);
    // R4: the free pulse never overlaps busy
    p_free_not_busy_r4: assert property (@(posedge clk) disable iff (rst)
        free_o |-> !busy_o);
    // R5: with tracking off, busy holds
    p_hold_when_off_r5: assert property (@(posedge clk) disable iff (rst)
        !trk_o |=> $stable(busy_o));
endmodule

// File: rtl/i2cbm_qual.sv
module i2cbm_qual #(
    parameter int IDLE_CYC = 1_000_000,
    parameter int TMO_CYC  = 10_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic trk_i,
    input  logic evt_i,
    input  logic hi_i,
    output logic valid_o,
    output logic tmo_o
);
    localparam int IW = $clog2(IDLE_CYC + 1);
    localparam int TW = $clog2(TMO_CYC + 1);
    localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYC - 1);
    localparam logic [TW-1:0] TMO_LAST  = TW'(TMO_CYC - 1);

    typedef struct packed {
        logic          valid;
        logic          tmo;
        logic [IW-1:0] idle;
        logic [TW-1:0] tcnt;
    } qual_t;

    qual_t st_d, st_q;
    logic  run, idle_done, settle;

    always_comb begin
        run       = trk_i && !st_q.valid && !st_q.tmo;
        idle_done = hi_i && (st_q.idle == IDLE_LAST);
        settle    = evt_i || idle_done;
        st_d      = st_q;
        if (run) begin
            if (settle) st_d.valid = 1'b1;
            st_d.idle = hi_i ? st_q.idle + 1'b1 : '0;
            if (!settle && (st_q.tcnt == TMO_LAST)) st_d.tmo = 1'b1;
            st_d.tcnt = st_q.tcnt + 1'b1;
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign tmo_o   = st_q.tmo;

    // R7: validity is sticky until reset
    p_valid_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> valid_o);
    // R9: a low sample during qualification clears the idle count
    p_idle_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (run && !hi_i) |=> (st_q.idle == '0));
    // R10: timeout is sticky and excludes validity
    p_tmo_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        tmo_o |=> (tmo_o && !valid_o));
    p_tmo_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(tmo_o && valid_o));
endmodule

// File: rtl/i2c_busy_monitor.sv
module i2c_busy_monitor
    import i2cbm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_CYC    = 1_000_000,
    parameter int TMO_CYC     = 10_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic sda_in,
    input  logic scl_in,
    input  logic ctl_en,
    input  logic start_req,
    output logic busy,
    output logic bus_free,
    output logic busy_valid,
    output logic qual_timeout,
    output logic start_go,
    output logic start_blocked
);
    line_t raw, cur;
    logic  prev_sda, trk, evt, hi;

    assign raw.sda = sda_in;
    assign raw.scl = scl_in;

    i2cbm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .raw_i      (raw),
        .sync_o     (cur),
        .prev_sda_o (prev_sda)
    );

    i2cbm_track u_track (
        .clk        (clk),
        .rst        (rst),
        .en_req_i   (ctl_en),
        .raw_i      (raw),
        .cur_i      (cur),
        .prev_sda_i (prev_sda),
        .busy_o     (busy),
        .free_o     (bus_free),
        .trk_o      (trk),
        .evt_o      (evt),
        .hi_o       (hi)
    );

    i2cbm_qual #(.IDLE_CYC(IDLE_CYC), .TMO_CYC(TMO_CYC)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .trk_i   (trk),
        .evt_i   (evt),
        .hi_i    (hi),
        .valid_o (busy_valid),
        .tmo_o   (qual_timeout)
    );

    assign start_go      = start_req && busy_valid;
    assign start_blocked = start_req && !busy_valid;

    // R11: no start passes while busy is untrusted
    p_start_mask_r11: assert property (@(posedge clk) disable iff (rst)
        (start_req && !busy_valid) |-> (!start_go && start_blocked));
endmodule

// File: tb/sim_i2c_busy_monitor.sv
module sim_i2c_busy_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int IDLE = 16;
    localparam int TMO  = 200;

    logic clk = 1'b0;
    logic rst = 1'b1, sda = 1'b0, scl = 1'b1, en = 1'b0, req = 1'b0;
    logic busy, bus_free, busy_valid, qual_timeout, start_go, start_blocked;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_busy_monitor #(.SYNC_STAGES(2), .IDLE_CYC(IDLE), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst(rst), .sda_in(sda), .scl_in(scl), .ctl_en(en),
        .start_req(req), .busy(busy), .bus_free(bus_free),
        .busy_valid(busy_valid), .qual_timeout(qual_timeout),
        .start_go(start_go), .start_blocked(start_blocked));

    // Reference model built from the requirements
    logic m_s1d, m_s1c, m_s2d, m_s2c, m_pd, m_en, m_busy, m_free, m_valid, m_tmo;
    int   m_idle, m_tcnt;

    always @(posedge clk) begin
        logic lvl, stp, ev, hi, run, settle;
        if (rst) begin
            m_s1d = sda; m_s1c = scl; m_s2d = sda; m_s2c = scl; m_pd = sda;
            m_en = 0; m_free = 0; m_busy = !sda && scl;
            m_valid = 0; m_tmo = 0; m_idle = 0; m_tcnt = 0;
        end else begin
            lvl = !m_s2d && m_s2c;
            stp = !m_pd && m_s2d && m_s2c;
            ev  = m_en && (lvl || stp);
            hi  = m_s2d && m_s2c;
            run = m_en && !m_valid && !m_tmo;
            m_free = m_en && stp;
            if (m_en && stp) m_busy = 0;
            else if (m_en && lvl) m_busy = 1;
            if (run) begin
                settle = ev || (hi && m_idle == IDLE - 1);
                if (settle) m_valid = 1;
                m_idle = hi ? m_idle + 1 : 0;
                if (!settle && m_tcnt == TMO - 1) m_tmo = 1;
                m_tcnt++;
            end
            m_pd = m_s2d; m_s2d = m_s1d; m_s2c = m_s1c; m_s1d = sda; m_s1c = scl;
            m_en = en;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            chk(busy == m_busy, "R2/R3 busy vs model", busy, m_busy);
            chk(bus_free == m_free, "R4 bus_free vs model", bus_free, m_free);
            chk(busy_valid == m_valid, "R7 busy_valid vs model", busy_valid, m_valid);
            chk(qual_timeout == m_tmo, "R10 timeout vs model", qual_timeout, m_tmo);
            chk(start_go == (req && m_valid) && start_blocked == (req && !m_valid),
                "R11 start gating vs model", {start_go, start_blocked},
                {req && m_valid, req && !m_valid});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic summary();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        // R1: reset value follows the lines
        tick(3);
        chk(busy == 1, "R1 reset busy sda0 scl1", busy, 1);
        chk(!busy_valid && !bus_free && !qual_timeout, "R7 reset flags", busy_valid, 0);
        sda = 1; scl = 1; tick(2);
        chk(busy == 0, "R1 reset busy sda1 scl1", busy, 0);
        sda = 0; scl = 0; tick(2);
        chk(busy == 0, "R1 reset busy sda0 scl0", busy, 0);
        // R5: no tracking until enabled, then one clock later
        sda = 1; scl = 1; tick(1);
        rst = 0; sda = 0; tick(5);
        chk(busy == 0, "R5 busy frozen while disabled", busy, 0);
        en = 1; tick(1);
        chk(busy == 0, "R5 no tracking on first enabled edge", busy, 0);
        tick(1);
        chk(busy == 1, "R3 acknowledge level sets busy", busy, 1);
        chk(busy_valid == 1, "R7 event sets busy_valid", busy_valid, 1);
        req = 1; tick(1);
        chk(start_go == 1 && start_blocked == 0, "R11 start passes when valid", start_go, 1);
        // R6 / R4: STOP latency and pulse width
        sda = 1; tick(2);
        chk(busy == 1, "R6 synchronizer latency", busy, 1);
        tick(1);
        chk(busy == 0 && bus_free == 1, "R4 STOP clears busy with pulse", bus_free, 1);
        tick(1);
        chk(bus_free == 0, "R4 pulse lasts one cycle", bus_free, 0);
        // R2: START
        sda = 0; tick(3);
        chk(busy == 1, "R2 START sets busy", busy, 1);
        sda = 1; tick(4);
        // R8: idle window
        rst = 1; tick(2); rst = 0; tick(1);
        chk(start_blocked == 1 && start_go == 0, "R11 start blocked after reset", start_blocked, 1);
        tick(IDLE - 1);
        chk(busy_valid == 0, "R8 not valid before window ends", busy_valid, 0);
        tick(1);
        chk(busy_valid == 1, "R8 valid at end of idle window", busy_valid, 1);
        // R9: a one-cycle SCL glitch restarts the window
        rst = 1; tick(2); rst = 0; tick(5);
        scl = 0; tick(1); scl = 1;
        tick(IDLE);
        chk(busy_valid == 0, "R9 idle count restarted", busy_valid, 0);
        tick(6);
        chk(busy_valid == 1, "R9 valid after full window", busy_valid, 1);
        // R10: timeout
        rst = 1; tick(2); rst = 0;
        for (int i = 0; i < TMO / 4 + 10; i++) begin
            scl = 0; tick(1); scl = 1; tick(3);
        end
        chk(qual_timeout == 1 && busy_valid == 0, "R10 timeout raised", qual_timeout, 1);
        sda = 0; tick(4);
        chk(busy == 1, "R10 busy still tracks after timeout", busy, 1);
        chk(busy_valid == 0 && qual_timeout == 1, "R10 qualification stopped", busy_valid, 0);
        chk(start_blocked == 1, "R11 blocked after timeout", start_blocked, 1);
        // Random phase with a fixed seed
        void'($urandom(32'h5eed_12c0));
        rst = 1; sda = 1; scl = 1; tick(2); rst = 0;
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(199) == 0) rst = 1;
            else rst = 0;
            if ($urandom_range(49) == 0) en = ~en;
            if ($urandom_range(5) == 0) sda = ~sda;
            if ($urandom_range(5) == 0) scl = ~scl;
            req = $urandom_range(1);
            tick(1);
        end
        summary();
    end
endmodule